// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer with Status Polling

The block sits on the host side of a parallel flash bus. A client hands it one request at a time on a valid/ready interface. A request either programs one word at a target address or erases one or more sectors. The block writes the unlock and command cycles the flash expects. It then waits out the device's settling time and polls the status bit of the target location until the embedded operation reports completion. It finishes with a one-cycle response that is either clean or flagged as an error.

The target address is kept in an internal register. The address bus returns to zero whenever no strobe is active, and every poll re-presents the stored address. The client can therefore let go of the bus between polls. A poll budget bounds the wait. When the budget runs out, or when the client raises abort, the block writes a single reset command to put the device back into read mode. It then reports an error.

An erase of several sectors arrives as a burst of beats, one sector address per beat, with a last flag on the final beat. The first beat carries the full six-cycle erase prefix. Each later beat adds only its sector command.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, req_ready is 1, fl_we_n and fl_oe_n are 1, and resp_valid is 0.
- R2: A program request (req_erase=0) produces exactly four write strobes. Each strobe is a single cycle with fl_we_n low, and the (address, data) pairs are, in order: (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), (req_addr,req_data).
- R3: Every poll read (fl_oe_n low) of a program presents the req_addr latched when the request was accepted.
- R4: A program completes on the first poll where the status bits of fl_rdata equal the same bits of the programmed data. The response then has resp_err=0, and no further poll follows.
- R5: After the last program command write, at least RECOV_CYC cycles pass before the first poll read.
- R6: With DW=16 the status bits are bit 7 and bit 15, and both must match. With DW=8 only bit 7 is checked.
- R7: An erase burst writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55) and then (sector,0x30) for the first beat. Each later beat adds only (sector,0x30). While the block waits for the next beat, req_ready is 1, and any beat accepted then counts as a sector beat.
- R8: After the sector command of the beat flagged req_last, at least ERASE_QUIET_CYC cycles pass before the first poll read.
- R9: An erase polls at the first beat's sector address. It completes with resp_err=0 when all status bits read 1.
- R10: If POLL_LIMIT polls pass without completion, the block issues one write of 0xF0 at address 0. The next cycle it responds with resp_err=1.
- R11: Abort, raised while a request is in progress, stops further polls. The block issues the 0xF0 reset write and responds with resp_err=1.
- R12: fl_we_n and fl_oe_n are never low together, and fl_addr is 0 in every cycle where both are high.
- R13: resp_valid is a one-cycle pulse. req_ready is 0 from the acceptance of a program request until the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Beat accepted when high together with req_valid |
| req_erase | input | 1 | 1 = sector erase, 0 = word program |
| req_last | input | 1 | Final sector beat of an erase burst |
| req_addr | input | AW | Program address or sector address |
| req_data | input | DW | Program data |
| abort | input | 1 | Cancel the operation in progress |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Completion was a timeout or an abort |
| fl_addr | output | AW | Flash address bus, zero when idle |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, sampled while fl_oe_n is low |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_oe_n | output | 1 | Active-low read strobe |

## Verification
The hardest case to reach is a 16-bit status word whose low byte already reports completion while the high byte is still busy. An early finish there would hand the client a half-written word. The bench's flash model answers a set number of polls with bit 7 correct and bit 15 inverted, and it counts the reads the controller makes before finishing. The abort case is also hard to hit, because the window between the last command write and the first poll is only RECOV_CYC cycles long. The bench waits until the model has logged the fourth write and then pulses abort inside that window.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_EWAIT,
        ST_RECOV,
        ST_QUIET,
        ST_POLL_RD,
        ST_POLL_GAP,
        ST_RST_WR,
        ST_RESP
    } fp_state_e;

    localparam logic [11:0] UNLOCK_A1 = 12'h555;
    localparam logic [11:0] UNLOCK_A2 = 12'h2AA;
    localparam logic [7:0]  UNLOCK_D1 = 8'hAA;
    localparam logic [7:0]  UNLOCK_D2 = 8'h55;
    localparam logic [7:0]  OP_PROG   = 8'hA0;
    localparam logic [7:0]  OP_ERSET  = 8'h80;
    localparam logic [7:0]  OP_SECT   = 8'h30;
    localparam logic [7:0]  OP_RESET  = 8'hF0;

    localparam int unsigned PROG_LAST_STEP  = 3;
    localparam int unsigned ERASE_LAST_STEP = 5;

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_poll_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          is_erase,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [AW-1:0] sect_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data
);
    localparam logic [AW-1:0] A1 = AW'(UNLOCK_A1);
    localparam logic [AW-1:0] A2 = AW'(UNLOCK_A2);

    always_comb begin
        cmd_addr = '0;
        cmd_data = '0;
        if (!is_erase) begin
            unique case (step)
                3'd0: begin cmd_addr = A1; cmd_data = DW'(UNLOCK_D1); end
                3'd1: begin cmd_addr = A2; cmd_data = DW'(UNLOCK_D2); end
                3'd2: begin cmd_addr = A1; cmd_data = DW'(OP_PROG);   end
                default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
            endcase
        end else begin
            unique case (step)
                3'd0: begin cmd_addr = A1; cmd_data = DW'(UNLOCK_D1); end
                3'd1: begin cmd_addr = A2; cmd_data = DW'(UNLOCK_D2); end
                3'd2: begin cmd_addr = A1; cmd_data = DW'(OP_ERSET);  end
                3'd3: begin cmd_addr = A1; cmd_data = DW'(UNLOCK_D1); end
                3'd4: begin cmd_addr = A2; cmd_data = DW'(UNLOCK_D2); end
                default: begin cmd_addr = sect_addr; cmd_data = DW'(OP_SECT); end
            endcase
        end
    end
endmodule

// File: rtl/flash_status_judge.sv
module flash_status_judge #(
    parameter int unsigned DW = 16
) (
    input  logic          is_erase,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] wdata,
    output logic          complete
);
    logic [DW-1:0] mask;
    logic [DW-1:0] expect_v;

    generate
        if (DW == 16) begin : g_word
            assign mask = DW'(16'h8080);
        end else begin : g_byte
            assign mask = DW'(8'h80);
        end
    endgenerate

    assign expect_v = is_erase ? {DW{1'b1}} : wdata;
    assign complete = ((rdata ^ expect_v) & mask) == '0;
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int unsigned AW              = 20,
    parameter int unsigned DW              = 16,
    parameter int unsigned RECOV_CYC       = 300,
    parameter int unsigned ERASE_QUIET_CYC = 5000,
    parameter int unsigned POLL_LIMIT      = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_erase,
    input  logic          req_last,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          abort,
    output logic          resp_valid,
    output logic          resp_err,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int unsigned TMAX = (RECOV_CYC > ERASE_QUIET_CYC) ? RECOV_CYC : ERASE_QUIET_CYC;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned PW   = $clog2(POLL_LIMIT + 1);
    localparam logic [TW-1:0] RECOV_LOAD = TW'(RECOV_CYC - 1);
    localparam logic [TW-1:0] QUIET_LOAD = TW'(ERASE_QUIET_CYC - 1);
    localparam logic [PW-1:0] PCNT_LAST  = PW'(POLL_LIMIT - 1);

    typedef struct packed {
        fp_state_e     st;
        logic          ph;
        logic [2:0]    step;
        logic [TW-1:0] tmr;
        logic [PW-1:0] pcnt;
        logic [AW-1:0] addr;
        logic [AW-1:0] sect;
        logic [DW-1:0] data;
        logic          erase;
        logic          last;
        logic          err;
    } fp_regs_t;

    fp_regs_t r_q, r_d;

    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          poll_ok;
    logic          last_step;
    logic          busy;

    flash_cmd_seq #(.AW(AW), .DW(DW)) seq_i (
        .is_erase (r_q.erase),
        .step     (r_q.step),
        .tgt_addr (r_q.addr),
        .sect_addr(r_q.sect),
        .tgt_data (r_q.data),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data)
    );

    flash_status_judge #(.DW(DW)) judge_i (
        .is_erase(r_q.erase),
        .rdata   (fl_rdata),
        .wdata   (r_q.data),
        .complete(poll_ok)
    );

    assign last_step = r_q.erase ? (r_q.step == 3'(ERASE_LAST_STEP))
                                 : (r_q.step == 3'(PROG_LAST_STEP));

    assign busy = (r_q.st != ST_IDLE) && (r_q.st != ST_RST_WR) && (r_q.st != ST_RESP);

    always_comb begin
        r_d = r_q;
        if (busy && abort) begin
            r_d.st  = ST_RST_WR;
            r_d.err = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (req_valid) begin
                        r_d.st    = ST_CMD;
                        r_d.addr  = req_addr;
                        r_d.sect  = req_addr;
                        r_d.data  = req_data;
                        r_d.erase = req_erase;
                        r_d.last  = req_last;
                        r_d.step  = '0;
                        r_d.ph    = 1'b0;
                        r_d.pcnt  = '0;
                        r_d.err   = 1'b0;
                    end
                end
                ST_CMD: begin
                    if (!r_q.ph) begin
                        r_d.ph = 1'b1;
                    end else begin
                        r_d.ph = 1'b0;
                        if (!last_step) begin
                            r_d.step = r_q.step + 3'd1;
                        end else if (!r_q.erase) begin
                            r_d.st  = ST_RECOV;
                            r_d.tmr = RECOV_LOAD;
                        end else if (r_q.last) begin
                            r_d.st  = ST_QUIET;
                            r_d.tmr = QUIET_LOAD;
                        end else begin
                            r_d.st = ST_EWAIT;
                        end
                    end
                end
                ST_EWAIT: begin
                    if (req_valid) begin
                        r_d.st   = ST_CMD;
                        r_d.sect = req_addr;
                        r_d.last = req_last;
                        r_d.ph   = 1'b0;
                    end
                end
                ST_RECOV, ST_QUIET: begin
                    if (r_q.tmr == '0) begin
                        r_d.st = ST_POLL_RD;
                    end else begin
                        r_d.tmr = r_q.tmr - TW'(1);
                    end
                end
                ST_POLL_RD: begin
                    if (poll_ok) begin
                        r_d.st = ST_RESP;
                    end else if (r_q.pcnt == PCNT_LAST) begin
                        r_d.st  = ST_RST_WR;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.pcnt = r_q.pcnt + PW'(1);
                        r_d.st   = ST_POLL_GAP;
                    end
                end
                ST_POLL_GAP: r_d.st = ST_POLL_RD;
                ST_RST_WR:   r_d.st = ST_RESP;
                ST_RESP:     r_d.st = ST_IDLE;
                default:     r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        fl_addr  = '0;
        fl_wdata = '0;
        fl_we_n  = 1'b1;
        fl_oe_n  = 1'b1;
        if (r_q.st == ST_CMD && !r_q.ph) begin
            fl_addr  = cmd_addr;
            fl_wdata = cmd_data;
            fl_we_n  = 1'b0;
        end else if (r_q.st == ST_RST_WR) begin
            fl_wdata = DW'(OP_RESET);
            fl_we_n  = 1'b0;
        end else if (r_q.st == ST_POLL_RD) begin
            fl_addr = r_q.addr;
            fl_oe_n = 1'b0;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE) || (r_q.st == ST_EWAIT);
    assign resp_valid = (r_q.st == ST_RESP);
    assign resp_err   = (r_q.st == ST_RESP) && r_q.err;

endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
    parameter int unsigned AW = 20,
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          resp_valid,
    input logic          resp_err,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_wdata,
    input logic          fl_we_n,
    input logic          fl_oe_n
);
    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    // R12
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_n && fl_oe_n) |-> (fl_addr == '0));

    // R13
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R13
    ready_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

    // R10
    err_reset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> ($past(!fl_we_n) && ($past(fl_wdata[7:0]) == 8'hF0)));
endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .resp_valid(resp_valid),
    .resp_err  (resp_err),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n)
);

// File: tb/flash_poll_ctrl_tb_top.sv
module flash_poll_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int RECOV = 8;
    localparam int QUIET = 20;
    localparam int PLIM = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_erase = 1'b0, req_last = 1'b0, abort = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, resp_valid, resp_err, fl_we_n, fl_oe_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata, fl_rdata;

    always #10 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .DW(DW), .RECOV_CYC(RECOV), .ERASE_QUIET_CYC(QUIET),
                      .POLL_LIMIT(PLIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_last(req_last), .req_addr(req_addr),
        .req_data(req_data), .abort(abort), .resp_valid(resp_valid),
        .resp_err(resp_err), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    logic [AW-1:0] wa [32];
    logic [DW-1:0] wd [32];
    int wn, wlast, rn, rfirst, rbad, relviol;
    logic [AW-1:0] pexp;
    int busy_left;
    logic [DW-1:0] good_v, busy_v;
    logic got_err;

    assign fl_rdata = fl_oe_n ? '0 : ((busy_left > 0) ? busy_v : good_v);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && !fl_we_n) begin
            if (wn < 32) begin
                wa[wn] = fl_addr;
                wd[wn] = fl_wdata;
            end
            wn = wn + 1;
            wlast = cyc;
        end
        if (rst_n && !fl_oe_n) begin
            if (rn == 0) rfirst = cyc;
            rn = rn + 1;
            if (fl_addr != pexp) rbad = rbad + 1;
            if (busy_left > 0) busy_left = busy_left - 1;
        end
        if (rst_n && fl_we_n && fl_oe_n && fl_addr != '0) relviol = relviol + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        wn = 0; rn = 0; rbad = 0; rfirst = 0; wlast = 0;
    endtask

    task automatic send(input bit er, input bit last, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_erase = er; req_last = last; req_addr = a; req_data = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_resp();
        int k = 0;
        while (!resp_valid && k < 5000) begin
            @(negedge clk);
            k++;
        end
        got_err = resp_err;
        chk(resp_valid, "R13 response seen", int'(resp_valid), 1);
        @(negedge clk);
        chk(!resp_valid, "R13 response one cycle", int'(resp_valid), 0);
    endtask

    task automatic chk_w(input int i, input int a, input int d, input string req);
        chk(wa[i] == AW'(a), req, int'(wa[i]), a);
        chk(wd[i] == DW'(d), req, int'(wd[i]), d);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(fl_we_n == 1'b1, "R1 we_n", int'(fl_we_n), 1);
        chk(fl_oe_n == 1'b1, "R1 oe_n", int'(fl_oe_n), 1);
        chk(resp_valid == 1'b0, "R1 resp", int'(resp_valid), 0);
    endtask

    task automatic t_program(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [DW-1:0] flip, input int nbusy, input string req);
        clear_logs();
        pexp = a; good_v = d; busy_v = d ^ flip; busy_left = nbusy;
        send(1'b0, 1'b0, a, d);
        chk(req_ready == 1'b0, "R13 ready low while busy", int'(req_ready), 0);
        wait_resp();
        chk(got_err == 1'b0, "R4 program ok", int'(got_err), 0);
        chk(wn == 4, "R2 write count", wn, 4);
        chk_w(0, 'h555, 'hAA, "R2 cycle1");
        chk_w(1, 'h2AA, 'h55, "R2 cycle2");
        chk_w(2, 'h555, 'hA0, "R2 cycle3");
        chk_w(3, int'(a), int'(d), "R2 target");
        chk(rn == nbusy + 1, req, rn, nbusy + 1);
        chk(rbad == 0, "R3 poll address", rbad, 0);
        chk(rfirst - wlast >= RECOV + 1, "R5 recovery wait", rfirst - wlast, RECOV + 1);
    endtask

    task automatic t_erase();
        clear_logs();
        pexp = 16'h4000; good_v = 16'hFFFF; busy_v = 16'h7F7F; busy_left = 3;
        send(1'b1, 1'b0, 16'h4000, '0);
        send(1'b1, 1'b1, 16'h8000, '0);
        wait_resp();
        chk(got_err == 1'b0, "R9 erase ok", int'(got_err), 0);
        chk(wn == 7, "R7 write count", wn, 7);
        chk_w(0, 'h555, 'hAA, "R7 c1");
        chk_w(1, 'h2AA, 'h55, "R7 c2");
        chk_w(2, 'h555, 'h80, "R7 c3");
        chk_w(3, 'h555, 'hAA, "R7 c4");
        chk_w(4, 'h2AA, 'h55, "R7 c5");
        chk_w(5, 'h4000, 'h30, "R7 sector1");
        chk_w(6, 'h8000, 'h30, "R7 sector2");
        chk(rn == 4, "R9 erase poll count", rn, 4);
        chk(rbad == 0, "R9 erase poll address", rbad, 0);
        chk(rfirst - wlast >= QUIET + 1, "R8 quiet window", rfirst - wlast, QUIET + 1);
    endtask

    task automatic t_timeout();
        clear_logs();
        pexp = 16'h0123; good_v = 16'h00FF; busy_v = 16'h007F; busy_left = 1000;
        send(1'b0, 1'b0, 16'h0123, 16'h00FF);
        wait_resp();
        chk(got_err == 1'b1, "R10 timeout error", int'(got_err), 1);
        chk(rn == PLIM, "R10 poll limit", rn, PLIM);
        chk(wn == 5, "R10 reset write count", wn, 5);
        chk_w(4, 0, 'hF0, "R10 reset write");
    endtask

    task automatic t_abort();
        int k = 0;
        clear_logs();
        pexp = 16'h0222; good_v = 16'h1234; busy_v = 16'h12B4; busy_left = 0;
        send(1'b0, 1'b0, 16'h0222, 16'h1234);
        while (wn < 4 && k < 100) begin
            @(negedge clk);
            k++;
        end
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_resp();
        chk(got_err == 1'b1, "R11 abort error", int'(got_err), 1);
        chk(rn == 0, "R11 no poll after abort", rn, 0);
        chk(wn == 5, "R11 write count", wn, 5);
        chk_w(4, 0, 'hF0, "R11 reset write");
    endtask

    initial begin
        relviol = 0; wn = 0; rn = 0; rbad = 0; busy_left = 0;
        good_v = '0; busy_v = '0; pexp = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_program(16'h1A2B, 16'h5CC3, 16'h0080, 3, "R4 stops at first match");
        t_program(16'h0F0E, 16'h80A5, 16'h8000, 4, "R6 bit15 must also match");
        t_erase();
        t_timeout();
        t_abort();
        chk(relviol == 0, "R12 bus released between strobes", relviol, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule